// File: doc/BRIEF.md
# DDR Bank Read Timing Tracker

This block follows the row state of each bank of a DDR SDRAM device as a memory controller sends it decoded commands. Each bank is idle, open, or closing on its own after a read with auto-precharge. Every command is judged legal or illegal against that state. Reads are also checked against a programmed activate-to-read delay. One cycle after each command the block raises exactly one of two flags to give the verdict.

For each legal read, the block opens a data-valid window on the shared read path. The window starts a programmed CAS latency after the read. It lasts half the burst length, because data moves on both clock edges. A precharge that hits the bank owning the burst closes the window early. A read with auto-precharge cannot be interrupted: the bank stays busy until its burst ends and then returns to idle by itself.

Opcodes on `cmd_op` are: 0 activate, 1 read, 2 read with auto-precharge, 3 precharge, 4 precharge-all. Codes 5 to 7 are reserved. Reset is synchronous and active high.

Top module: `ddr_read_tracker`

## Requirements
- R1: After reset every bit of `bank_idle` is 1, and `cmd_ok`, `cmd_bad` and `rd_valid` are 0.
- R2: An activate (op 0) to an idle bank is legal, and that bank's `bank_idle` bit reads 0 from the next cycle. An activate to a bank that is not idle is illegal and changes no state.
- R3: A read (op 1 or 2) to an open bank is illegal until at least `cfg_trcd` cycles have passed since its activate (a value of 0 acts as 1). A read issued that early starts no data window.
- R4: A read to an idle bank is illegal and `rd_valid` stays 0.
- R5: After a legal read, `rd_valid` first reads 1 exactly `cfg_cl` cycles after the read's cycle (a value of 0 acts as 1), and `rd_bank` shows the read's bank while `rd_valid` is 1.
- R6: `cfg_bl` holds the burst length in data beats (2, 4 or 8), and the window stays high for `cfg_bl`/2 consecutive cycles.
- R7: A legal precharge (op 3) to the bank that owns a pending or running burst cancels the burst: `rd_valid` reads 0 from the next cycle, and the bank reads idle from the next cycle.
- R8: After a read with auto-precharge, the bank reads not idle until its last valid cycle and reads idle in the cycle after that.
- R9: While a read with auto-precharge is in flight on a bank, every command addressed to that bank is illegal and has no effect. This covers activate, read, precharge and precharge-all, and the running window is not shortened.
- R10: Precharge-all (op 4) is legal when no auto-precharge read is in flight. From the next cycle every bank reads idle and any burst is cancelled.
- R11: A read issued while an earlier read's latency or burst is still in progress is illegal and leaves the earlier window unchanged.
- R12: Exactly one of `cmd_ok`/`cmd_bad` is 1 in the cycle after a valid command, and neither is 1 after a cycle with no command. Reserved opcodes 5 to 7 are illegal. A precharge to an idle bank is legal and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command opcode (0 act, 1 rd, 2 rd+ap, 3 pre, 4 pre-all) |
| cmd_bank | input | 2 | Target bank |
| cfg_trcd | input | 4 | Activate-to-read delay in cycles |
| cfg_cl | input | 3 | CAS latency in cycles |
| cfg_bl | input | 4 | Burst length in data beats |
| bank_idle | output | 4 | One bit per bank, 1 when the bank is idle |
| cmd_ok | output | 1 | Previous cycle's command was legal |
| cmd_bad | output | 1 | Previous cycle's command was illegal |
| rd_valid | output | 1 | Read data window is open |
| rd_bank | output | 2 | Bank that owns the current read window |

## Verification
The verdict flags and the bank idle bits are registered, so they are due one cycle after the command's edge. The first `rd_valid` cycle is due `cfg_cl` edges after the read. A cancelling precharge drops the window one cycle after its own edge. The bench drives commands on falling edges and counts the falling edges after each one. It compares every sampled cycle of a window against the expected span computed from latency and burst length, so early, late, short and long windows all show up as mismatches. Commands injected into the middle of an auto-precharge read or a running burst are placed at chosen falling edges, and their verdicts are read one cycle later.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ACT  = 3'd0,
    OP_RD   = 3'd1,
    OP_RDA  = 3'd2,
    OP_PRE  = 3'd3,
    OP_PREA = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_APRD = 2'd2
  } bk_e;
endpackage

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_trk_pkg::*;
#(
  parameter int TRCD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TRCD_W-1:0] cfg_trcd,
  input  logic              do_act,
  input  logic              do_rd,
  input  logic              do_rda,
  input  logic              do_pre,
  input  logic              ap_done,
  output bk_e               st,
  output logic              rcd_ok
);
  logic [TRCD_W-1:0] rcd_cnt;

  // cycles still to wait after the activate edge; zero behaves as one
  function automatic logic [TRCD_W-1:0] rcd_load(input logic [TRCD_W-1:0] t);
    return (t == '0) ? '0 : t - TRCD_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BK_IDLE;
      rcd_cnt <= '0;
    end else begin
      if (do_act)              rcd_cnt <= rcd_load(cfg_trcd);
      else if (rcd_cnt != '0)  rcd_cnt <= rcd_cnt - TRCD_W'(1);

      if (do_act)       st <= BK_OPEN;
      else if (do_rda)  st <= BK_APRD;
      else if (do_pre)  st <= BK_IDLE;
      else if (ap_done) st <= BK_IDLE;
    end
  end

  assign rcd_ok = (rcd_cnt == '0);

  // R3: a read only passes the decode when the delay has elapsed on an open bank
  p_rcd_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (do_rd || do_rda) |-> (rcd_ok && st == BK_OPEN));

  // R2: an accepted activate opens the bank
  p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
    do_act |=> (st == BK_OPEN));

  // R9: an auto-precharge read holds the bank until its burst completes
  p_ap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st == BK_APRD && !ap_done) |=> (st == BK_APRD));

  // R9: no precharge or activate reaches a bank closing on its own
  p_ap_no_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    (st == BK_APRD) |-> !(do_act || do_pre || do_rd || do_rda));
endmodule

// File: rtl/ddr_burst_ctl.sv
module ddr_burst_ctl #(
  parameter int BA_W = 2,
  parameter int CL_W = 3,
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BA_W-1:0] start_bank,
  input  logic            start_ap,
  input  logic [CL_W-1:0] cfg_cl,
  input  logic [BL_W-1:0] cfg_bl,
  input  logic            kill,
  output logic            rd_valid,
  output logic [BA_W-1:0] rd_bank,
  output logic            busy,
  output logic            owner_ap,
  output logic            ap_done
);
  logic            pend;
  logic [CL_W-1:0] lat_cnt;
  logic [BL_W-1:0] beats_left;

  // latency counter start value; zero behaves as one
  function automatic logic [CL_W-1:0] lat_load(input logic [CL_W-1:0] cl);
    return (cl == '0) ? CL_W'(1) : cl;
  endfunction

  // beats remaining after the first valid cycle: BL/2 - 1, at least zero
  function automatic logic [BL_W-1:0] beat_load(input logic [BL_W-1:0] bl);
    logic [BL_W-1:0] half;
    half = bl >> 1;
    return (half == '0) ? '0 : half - BL_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      rd_valid   <= 1'b0;
      lat_cnt    <= '0;
      beats_left <= '0;
      rd_bank    <= '0;
      owner_ap   <= 1'b0;
    end else if (kill) begin
      pend     <= 1'b0;
      rd_valid <= 1'b0;
      owner_ap <= 1'b0;
    end else if (start) begin
      pend       <= 1'b1;
      lat_cnt    <= lat_load(cfg_cl);
      beats_left <= beat_load(cfg_bl);
      rd_bank    <= start_bank;
      owner_ap   <= start_ap;
    end else if (pend) begin
      if (lat_cnt == CL_W'(1)) begin
        pend     <= 1'b0;
        rd_valid <= 1'b1;
      end else begin
        lat_cnt <= lat_cnt - CL_W'(1);
      end
    end else if (rd_valid) begin
      if (beats_left == '0) begin
        rd_valid <= 1'b0;
        owner_ap <= 1'b0;
      end else begin
        beats_left <= beats_left - BL_W'(1);
      end
    end
  end

  assign busy    = pend || rd_valid;
  assign ap_done = rd_valid && (beats_left == '0) && owner_ap;

  // R7: a cancel closes the window on the next cycle
  p_kill_closes_r7: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!rd_valid && !busy));

  // R11: a new burst is only accepted on an idle data path
  p_start_free_r11: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R5: the window only opens out of the latency phase
  p_open_after_lat_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> $past(pend));

  // R9: an auto-precharge burst is never cancelled
  p_ap_no_kill_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && owner_ap) |-> !kill);
endmodule

// File: rtl/ddr_read_tracker.sv
module ddr_read_tracker
  import ddr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRCD_W    = 4,
  parameter int CL_W      = 3,
  parameter int BL_W      = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [OP_W-1:0]      cmd_op,
  input  logic [BA_W-1:0]      cmd_bank,
  input  logic [TRCD_W-1:0]    cfg_trcd,
  input  logic [CL_W-1:0]      cfg_cl,
  input  logic [BL_W-1:0]      cfg_bl,
  output logic [NUM_BANKS-1:0] bank_idle,
  output logic                 cmd_ok,
  output logic                 cmd_bad,
  output logic                 rd_valid,
  output logic [BA_W-1:0]      rd_bank
);
  logic [NUM_BANKS-1:0] open_v, ap_v, rcd_ok_v, idle_v;
  logic busy, owner_ap, ap_done, legal, is_rd, is_pre_any, kill, start;

  // legality of the presented command against the current bank states
  always_comb begin
    legal = 1'b0;
    case (cmd_op)
      OP_ACT:        legal = idle_v[cmd_bank];
      OP_RD, OP_RDA: legal = open_v[cmd_bank] && rcd_ok_v[cmd_bank] && !busy;
      OP_PRE:        legal = !ap_v[cmd_bank];
      OP_PREA:       legal = !(|ap_v);
      default:       legal = 1'b0;
    endcase
  end

  assign is_rd      = (cmd_op == OP_RD) || (cmd_op == OP_RDA);
  assign is_pre_any = (cmd_op == OP_PREA) || ((cmd_op == OP_PRE) && (cmd_bank == rd_bank));
  assign start      = cmd_valid && legal && is_rd;
  assign kill       = cmd_valid && legal && busy && is_pre_any;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit, do_pre;
    bk_e  st;
    assign hit    = cmd_valid && legal && (cmd_bank == BA_W'(i));
    assign do_pre = (hit && cmd_op == OP_PRE) ||
                    (cmd_valid && legal && cmd_op == OP_PREA);

    ddr_bank_fsm #(.TRCD_W(TRCD_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .cfg_trcd (cfg_trcd),
      .do_act   (hit && cmd_op == OP_ACT),
      .do_rd    (hit && cmd_op == OP_RD),
      .do_rda   (hit && cmd_op == OP_RDA),
      .do_pre   (do_pre),
      .ap_done  (ap_done && (rd_bank == BA_W'(i))),
      .st       (st),
      .rcd_ok   (rcd_ok_v[i])
    );

    assign idle_v[i] = (st == BK_IDLE);
    assign open_v[i] = (st == BK_OPEN);
    assign ap_v[i]   = (st == BK_APRD);
  end

  ddr_burst_ctl #(.BA_W(BA_W), .CL_W(CL_W), .BL_W(BL_W)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_bank (cmd_bank),
    .start_ap   (cmd_op == OP_RDA),
    .cfg_cl     (cfg_cl),
    .cfg_bl     (cfg_bl),
    .kill       (kill),
    .rd_valid   (rd_valid),
    .rd_bank    (rd_bank),
    .busy       (busy),
    .owner_ap   (owner_ap),
    .ap_done    (ap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_ok  <= 1'b0;
      cmd_bad <= 1'b0;
    end else begin
      cmd_ok  <= cmd_valid && legal;
      cmd_bad <= cmd_valid && !legal;
    end
  end

  assign bank_idle = idle_v;

  // R12: the two verdict flags never rise together
  p_flags_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(cmd_ok && cmd_bad));

  // R10: an accepted precharge-all leaves every bank idle
  p_prea_all_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && legal && cmd_op == OP_PREA) |=> (&bank_idle && !rd_valid));

  // R8: an auto-precharge owner bank is never reported idle during its burst
  p_ap_owner_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && owner_ap) |-> !bank_idle[rd_bank]);
endmodule

// File: tb/tb_ddr_read_tracker.sv
`timescale 1ns/1ps
module tb_ddr_read_tracker;
  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [1:0] cmd_bank;
  logic [3:0] cfg_trcd;
  logic [2:0] cfg_cl;
  logic [3:0] cfg_bl;
  logic [3:0] bank_idle;
  logic       cmd_ok, cmd_bad, rd_valid;
  logic [1:0] rd_bank;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  localparam logic [2:0] ACT = 3'd0, RD = 3'd1, RDA = 3'd2, PRE = 3'd3, PREA = 3'd4;

  always #2.5 clk = ~clk;

  ddr_read_tracker dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cfg_trcd(cfg_trcd), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl), .bank_idle(bank_idle),
    .cmd_ok(cmd_ok), .cmd_bad(cmd_bad), .rd_valid(rd_valid), .rd_bank(rd_bank)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] bank);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank;
  endtask

  // verdict code: 2 = ok, 1 = bad, 0 = none
  function automatic int verdict();
    return {cmd_ok, cmd_bad};
  endfunction

  task automatic issue(input logic [2:0] op, input logic [1:0] bank);
    drive(op, bank);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // read window: high on falling edges first .. first+len-1 after the drive edge
  task automatic watch(input string req, input int first, input int len, input int n,
                       input logic [1:0] bnk);
    int mism = 0;
    for (int j = 1; j <= n; j++) begin
      if (j > 1) @(negedge clk);
      if (rd_valid != (j >= first && j < first + len)) mism++;
      if (rd_valid && rd_bank != bnk) mism++;
    end
    chk(req, "window mismatches", mism, 0);
  endtask

  task automatic t_reset();
    chk("R1", "bank_idle", bank_idle, 4'hF);
    chk("R1", "flags", verdict(), 0);
    chk("R1", "rd_valid", rd_valid, 0);
  endtask

  task automatic t_activate();
    issue(ACT, 2'd0);
    chk("R2", "act idle verdict", verdict(), 2);
    chk("R2", "bank_idle after act", bank_idle, 4'b1110);
    issue(ACT, 2'd0);
    chk("R2", "act open verdict", verdict(), 1);
    chk("R2", "bank_idle unchanged", bank_idle, 4'b1110);
  endtask

  task automatic t_rcd_latency();
    cfg_trcd = 4'd3; cfg_cl = 3'd2; cfg_bl = 4'd4;
    issue(ACT, 2'd1);
    issue(RD, 2'd1);
    chk("R3", "read 1 cycle after act", verdict(), 1);
    issue(RD, 2'd1);
    chk("R3", "read 2 cycles after act", verdict(), 1);
    chk("R3", "no window from early read", rd_valid, 0);
    issue(RD, 2'd1);
    chk("R3", "read 3 cycles after act", verdict(), 2);
    watch("R5", 3, 2, 8, 2'd1);
  endtask

  task automatic t_idle_read();
    issue(RD, 2'd2);
    chk("R4", "read idle bank", verdict(), 1);
    watch("R4", 99, 0, 6, 2'd0);
    issue(PRE, 2'd1);
    chk("R12", "precharge open bank", verdict(), 2);
  endtask

  task automatic t_lengths();
    cfg_cl = 3'd3; cfg_bl = 4'd8;
    issue(RD, 2'd0);
    chk("R6", "read verdict", verdict(), 2);
    watch("R6", 4, 4, 10, 2'd0);
    cfg_cl = 3'd1; cfg_bl = 4'd2;
    issue(RD, 2'd0);
    watch("R5", 2, 1, 5, 2'd0);
  endtask

  task automatic t_trunc();
    int mism = 0;
    cfg_cl = 3'd2; cfg_bl = 4'd8;
    drive(RD, 2'd0);
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (rd_valid != (j == 3 || j == 4)) mism++;
      if (j == 5) begin
        chk("R7", "precharge verdict", verdict(), 2);
        chk("R7", "bank0 idle", bank_idle[0], 1);
      end
      if (j == 4) drive(PRE, 2'd0);
    end
    chk("R7", "truncated window mismatches", mism, 0);
    issue(ACT, 2'd0);
    repeat (3) @(negedge clk);
    drive(RD, 2'd0);
    mism = 0;
    for (int j = 1; j <= 7; j++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (rd_valid) mism++;
      if (j == 1) drive(PRE, 2'd0);
    end
    chk("R7", "cancel in latency mismatches", mism, 0);
  endtask

  task automatic t_autopre();
    int mism = 0, imis = 0;
    cfg_cl = 3'd2; cfg_bl = 4'd4;
    issue(ACT, 2'd0);
    issue(ACT, 2'd3);
    repeat (4) @(negedge clk);
    drive(RDA, 2'd3);
    for (int j = 1; j <= 7; j++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (rd_valid != (j == 3 || j == 4)) mism++;
      if (bank_idle[3] != (j >= 5)) imis++;
      if (j == 1) chk("R8", "rda verdict", verdict(), 2);
      if (j >= 2 && j <= 5) chk("R9", "command during ap read", verdict(), 1);
      case (j)
        1: drive(PRE, 2'd3);
        2: drive(ACT, 2'd3);
        3: drive(PREA, 2'd0);
        4: drive(RD, 2'd3);
        default: ;
      endcase
    end
    chk("R9", "ap window not shortened", mism, 0);
    chk("R8", "bank3 idle timing mismatches", imis, 0);
    chk("R9", "bank0 still open", bank_idle[0], 0);
    issue(ACT, 2'd3);
    chk("R8", "act after ap done", verdict(), 2);
  endtask

  task automatic t_prea();
    int mism = 0;
    cfg_cl = 3'd2; cfg_bl = 4'd8;
    issue(ACT, 2'd1);
    repeat (4) @(negedge clk);
    chk("R10", "three banks open", bank_idle, 4'b0100);
    drive(RD, 2'd1);
    for (int j = 1; j <= 7; j++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (rd_valid != (j == 3)) mism++;
      if (j == 4) begin
        chk("R10", "prea verdict", verdict(), 2);
        chk("R10", "all idle", bank_idle, 4'hF);
      end
      if (j == 3) drive(PREA, 2'd2);
    end
    chk("R10", "window cut by prea", mism, 0);
  endtask

  task automatic t_busy();
    int mism = 0;
    cfg_cl = 3'd3; cfg_bl = 4'd4;
    issue(ACT, 2'd0);
    issue(ACT, 2'd2);
    repeat (4) @(negedge clk);
    drive(RD, 2'd0);
    for (int j = 1; j <= 7; j++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (rd_valid != (j == 4 || j == 5)) mism++;
      if (rd_valid && rd_bank != 2'd0) mism++;
      if (j == 3) chk("R11", "read while busy", verdict(), 1);
      if (j == 2) drive(RD, 2'd2);
    end
    chk("R11", "first window intact", mism, 0);
    issue(RD, 2'd2);
    chk("R11", "read after path free", verdict(), 2);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_misc();
    issue(3'd7, 2'd0);
    chk("R12", "reserved op", verdict(), 1);
    @(negedge clk);
    chk("R12", "no command no flag", verdict(), 0);
    issue(PRE, 2'd1);
    chk("R12", "pre idle bank verdict", verdict(), 2);
    chk("R12", "pre idle bank state", bank_idle, 4'b1010);
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_bank = '0;
    cfg_trcd = 4'd3; cfg_cl = 3'd2; cfg_bl = 4'd4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_activate();
    t_rcd_latency();
    t_idle_read();
    t_lengths();
    t_trunc();
    t_autopre();
    t_prea();
    t_busy();
    t_misc();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule